// File: doc/BRIEF.md
# Interrupt Code Encoder with Block Masking

This block turns the interrupt requests that reach a processor core into one 12-bit exception code. There are two kinds of source. An external interrupt level arrives as a 4-bit number. Each on-chip peripheral event has its own request line. When one or more requests are active, a fixed priority picks a winner. The block then registers the winner's code and raises a one-cycle accept strobe.

A block bit from the status register controls what happens to requests:

- **Block bit set, interrupt request:** the request is not accepted. The block raises a pending flag for as long as the source stays active. When software clears the block bit, the request is accepted on the next clock edge. If the source goes away while the bit is still set, the request is dropped.
- **Block bit set, general exception:** the exception is not masked. The block raises a redirect request that sends the core to the reset address, so the core restarts as if it had been reset.

Top module: `irq_code_enc`

## Requirements
- R1: An external level n on `ext_lvl_i` in the range 4'b0000..4'b1110 encodes to code 12'h200 + n*12'h20 (4'b1001 gives 12'h320, 4'b1110 gives 12'h3C0). Level 4'b1111 means no external request.
- R2: Bit i of `periph_req_i` encodes to code 12'h400 + i*12'h20. The bits, from 0 up to 13, are:
  - bits 0..2: the three timer underflows;
  - bit 3: the timer input capture;
  - bits 4..6: the clock alarm, clock periodic and clock carry events;
  - bits 7..10: the serial error, receive, transmit and transmit-end events;
  - bits 11..13: the watchdog interval, refresh compare-match and refresh overflow events.
- R3: An active external level beats every peripheral line. Among peripheral lines, the lowest bit index (the lowest code) wins.
- R4: `code_o` never takes the reserved values 12'h120, 12'h140 or 12'h3E0.
- R5: Accepting a request works as follows:
  - When a request is active and `blk_i` is 0 at a clock edge, `accept_o` is 1 for exactly that following cycle.
  - `code_o` loads the winner's code at that edge and then holds it.
  - A winner that stays the same is not accepted again. A different winner is accepted.
- R6: While `blk_i` is 1, no request is accepted. `pending_o` is 1 in the cycle after each edge at which `blk_i` is 1 and a request is active.
- R7: A request that is held pending is accepted at the first edge after `blk_i` returns to 0, with its own code. At that same edge `pending_o` falls.
- R8: If a blocked source deasserts before `blk_i` clears, `pending_o` falls after the next edge. The request is not accepted when `blk_i` clears later.
- R9: When `gen_exc_i` and `blk_i` are both 1 at an edge, `redirect_o` is 1 in the following cycle and `redirect_addr_o` is 32'hA000_0000. When `gen_exc_i` arrives with `blk_i` at 0, `redirect_o` stays 0.
- R10: While `rst_ni` is low, `accept_o`, `pending_o`, `redirect_o` and `code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_lvl_i | input | 4 | Encoded external interrupt level (4'b1111 = none) |
| periph_req_i | input | 14 | Peripheral request lines, bit i maps to code 12'h400 + i*12'h20 |
| blk_i | input | 1 | Block bit from the status register |
| gen_exc_i | input | 1 | General exception event |
| accept_o | output | 1 | One-cycle accept strobe |
| code_o | output | 12 | Exception code of the last accepted request |
| pending_o | output | 1 | A request is being held off by the block bit |
| redirect_o | output | 1 | Reset-equivalent redirect request |
| redirect_addr_o | output | 32 | Branch target of the redirect |

## Verification
The hardest case to reach from the ports is a request that is held while the block bit is set and then either released or abandoned. Two things must both hold. First, the winner from before the block must not be accepted twice. Second, a source that dropped while blocked must not reappear once the bit clears.

The stimulus reaches this case by returning all inputs to idle, then raising `blk_i` before the request. It then either clears `blk_i` with the source still held, or withdraws the source first and clears `blk_i` afterwards. `accept_o` and `pending_o` are watched across several cycles around each step.

The 14 peripheral lines are also swept through every non-zero pattern, and every external level is tried, so that each priority winner is observed.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  parameter int unsigned CODE_W = 12;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t EXT_BASE    = 12'h200;
  localparam code_t PERIPH_BASE = 12'h400;
  localparam int unsigned STEP_SH = 5;  // codes are 0x20 apart

  typedef struct packed {
    logic  vld;
    code_t code;
  } req_t;
endpackage

// File: rtl/irq_lvl_enc.sv
module irq_lvl_enc
  import irq_enc_pkg::*;
#(
  parameter int unsigned LVL_W = 4
) (
  input  logic [LVL_W-1:0] lvl_i,
  output req_t             req_o
);
  localparam logic [LVL_W-1:0] NONE = '1;

  always_comb begin
    req_o.vld  = (lvl_i != NONE);
    req_o.code = EXT_BASE + (code_t'(lvl_i) << STEP_SH);
  end
endmodule

// File: rtl/irq_periph_prio.sv
module irq_periph_prio
  import irq_enc_pkg::*;
#(
  parameter int unsigned N = 14
) (
  input  logic [N-1:0] req_i,
  output req_t         req_o
);
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end

  always_comb begin
    req_o.vld  = seen[N];
    req_o.code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) req_o.code = req_o.code | (PERIPH_BASE + (code_t'(i) << STEP_SH));
    end
  end
endmodule

// File: rtl/irq_accept_ctl.sv
module irq_accept_ctl
  import irq_enc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  req_t  win_i,
  input  logic  blk_i,
  input  logic  gen_exc_i,
  output logic  accept_o,
  output code_t code_o,
  output logic  pending_o,
  output logic  redirect_o
);
  logic  last_vld_q;
  code_t last_code_q;
  logic  take;

  // re-accept only when the winner changes or the line went idle
  assign take = win_i.vld & ~blk_i & ~(last_vld_q & (last_code_q == win_i.code));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o    <= 1'b0;
      code_o      <= '0;
      pending_o   <= 1'b0;
      redirect_o  <= 1'b0;
      last_vld_q  <= 1'b0;
      last_code_q <= '0;
    end else begin
      accept_o    <= take;
      pending_o   <= win_i.vld & blk_i;
      redirect_o  <= gen_exc_i & blk_i;
      last_vld_q  <= win_i.vld & ~blk_i;
      last_code_q <= win_i.code;
      if (take) code_o <= win_i.code;
    end
  end
endmodule

// File: rtl/irq_code_enc.sv
module irq_code_enc
  import irq_enc_pkg::*;
#(
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned N_PERIPH  = 14,
  parameter logic [31:0] RESET_VEC = 32'hA000_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LVL_W-1:0]    ext_lvl_i,
  input  logic [N_PERIPH-1:0] periph_req_i,
  input  logic                blk_i,
  input  logic                gen_exc_i,
  output logic                accept_o,
  output logic [CODE_W-1:0]   code_o,
  output logic                pending_o,
  output logic                redirect_o,
  output logic [31:0]         redirect_addr_o
);
  req_t ext_req, per_req, win;

  irq_lvl_enc #(.LVL_W(LVL_W)) i_lvl (
    .lvl_i (ext_lvl_i),
    .req_o (ext_req)
  );

  irq_periph_prio #(.N(N_PERIPH)) i_prio (
    .req_i (periph_req_i),
    .req_o (per_req)
  );

  assign win = ext_req.vld ? ext_req : per_req;

  irq_accept_ctl i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_i      (win),
    .blk_i      (blk_i),
    .gen_exc_i  (gen_exc_i),
    .accept_o   (accept_o),
    .code_o     (code_o),
    .pending_o  (pending_o),
    .redirect_o (redirect_o)
  );

  assign redirect_addr_o = RESET_VEC;
endmodule

// File: rtl/irq_code_enc_chk.sv
module irq_code_enc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  ext_lvl_i,
  input logic        blk_i,
  input logic        gen_exc_i,
  input logic        accept_o,
  input logic [11:0] code_o,
  input logic        pending_o,
  input logic        redirect_o,
  input logic [31:0] redirect_addr_o
);
  // R4
  no_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_o != 12'h120 && code_o != 12'h140 && code_o != 12'h3E0);

  // R6
  blk_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !$past(blk_i));

  // R6
  pend_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_o && accept_o));

  // R9
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> ($past(gen_exc_i) && $past(blk_i) && redirect_addr_o == 32'hA000_0000));

  // R1
  ext_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(ext_lvl_i) != 4'hF) |-> code_o[11:9] == 3'b001);
endmodule

bind irq_code_enc irq_code_enc_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ext_lvl_i       (ext_lvl_i),
  .blk_i           (blk_i),
  .gen_exc_i       (gen_exc_i),
  .accept_o        (accept_o),
  .code_o          (code_o),
  .pending_o       (pending_o),
  .redirect_o      (redirect_o),
  .redirect_addr_o (redirect_addr_o)
);

// File: tb/test_irq_code_enc.sv
module test_irq_code_enc;
  localparam int N = 14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  ext_lvl_i = 4'hF;
  logic [N-1:0] periph_req_i = '0;
  logic        blk_i = 1'b0;
  logic        gen_exc_i = 1'b0;
  logic        accept_o, pending_o, redirect_o;
  logic [11:0] code_o;
  logic [31:0] redirect_addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  irq_code_enc i_irq_code_enc (
    .clk_i, .rst_ni, .ext_lvl_i, .periph_req_i, .blk_i, .gen_exc_i,
    .accept_o, .code_o, .pending_o, .redirect_o, .redirect_addr_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ext_lvl_i = 4'hF; periph_req_i = '0; blk_i = 0; gen_exc_i = 0;
    @(negedge clk_i);
  endtask

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk(!accept_o && !pending_o && !redirect_o && code_o == 0, "R10 reset", {accept_o, pending_o, redirect_o, code_o}, 0);
    rst_ni = 1;
    idle();

    // R1 external levels
    for (int n = 0; n < 15; n++) begin
      logic [11:0] e;
      idle();
      e = 12'h200 + 12'(n) * 12'h20;
      ext_lvl_i = 4'(n);
      step();
      chk(accept_o && code_o == e, "R1 ext level", {accept_o, code_o}, {1'b1, e});
      chk(code_o != 12'h120 && code_o != 12'h140 && code_o != 12'h3E0, "R4 reserved", code_o, e);
      step();
      chk(!accept_o && code_o == e, "R5 single pulse", {accept_o, code_o}, {1'b0, e});
    end
    idle(); step();
    chk(!accept_o, "R1 level 1111 no request", accept_o, 0);

    // R2/R3 every peripheral pattern
    for (int p = 1; p < (1 << N); p++) begin
      int k;
      logic [11:0] e;
      idle();
      k = 0;
      while (((p >> k) & 1) == 0) k++;
      e = 12'h400 + 12'(k) * 12'h20;
      periph_req_i = N'(p);
      step();
      chk(accept_o && code_o == e, ($countones(p) == 1) ? "R2 periph code" : "R3 periph priority",
          {accept_o, code_o}, {1'b1, e});
    end

    // R3 external beats peripheral
    idle();
    ext_lvl_i = 4'd5; periph_req_i = 14'h0001;
    step();
    chk(accept_o && code_o == 12'h2A0, "R3 ext over periph", code_o, 12'h2A0);

    // R5 new winner re-accepted
    idle();
    periph_req_i = 14'h0008;
    step();
    chk(accept_o && code_o == 12'h460, "R5 first winner", code_o, 12'h460);
    step();
    chk(!accept_o, "R5 held winner not re-accepted", accept_o, 0);
    periph_req_i = 14'h000A;
    step();
    chk(accept_o && code_o == 12'h420, "R5 new winner accepted", code_o, 12'h420);

    // R6/R7 blocked then released
    idle();
    blk_i = 1; step();
    periph_req_i = 14'h0004;
    for (int c = 0; c < 4; c++) begin
      step();
      chk(pending_o && !accept_o, "R6 blocked pending", {pending_o, accept_o}, 2'b10);
    end
    blk_i = 0;
    step();
    chk(accept_o && !pending_o && code_o == 12'h440, "R7 release accept", {accept_o, pending_o, code_o}, {2'b10, 12'h440});

    // R8 dropped while blocked
    idle();
    blk_i = 1; ext_lvl_i = 4'd3;
    step();
    chk(pending_o && !accept_o, "R8 pending set", pending_o, 1);
    ext_lvl_i = 4'hF;
    step();
    chk(!pending_o, "R8 pending dropped", pending_o, 0);
    blk_i = 0;
    step();
    chk(!accept_o, "R8 no accept after release", accept_o, 0);
    step();
    chk(!accept_o && !pending_o, "R8 stays quiet", {accept_o, pending_o}, 0);

    // R9 redirect
    idle();
    blk_i = 1; gen_exc_i = 1;
    step();
    chk(redirect_o && redirect_addr_o == 32'hA000_0000, "R9 redirect", redirect_addr_o, 32'hA000_0000);
    gen_exc_i = 0;
    step();
    chk(!redirect_o, "R9 redirect ends", redirect_o, 0);
    blk_i = 0; gen_exc_i = 1;
    step();
    chk(!redirect_o, "R9 no redirect unblocked", redirect_o, 0);
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule